// File: doc/BRIEF.md
# Prioritized Clock Reference Selector

This block decides which of several candidate clock references feeds a timing DPLL, and tracks the DPLL's coarse operating state. Each input carries a priority value, a validity flag from an external monitor and a phase-alarm flag that this block latches. On every clock the selector picks the best qualified input. In revertive mode a better input takes over at once. In non-revertive mode the current input is kept for as long as it stays qualified.

A 4-bit force register can name one input. That input's effective priority is raised to the top level, and it wins ties at that level. It is treated as qualified whatever its monitors say, so the state machine never falls into holdover while a force is active. Phase alarms clear either through a software write or, when ageing is enabled, after a fixed number of one-per-second ticks. A small register port gives access to the force code, the mode byte and the alarm flags.

The state machine has four states: FREERUN (no source yet), LOCKING (a source is selected and the DPLL is pulling in), LOCKED (the DPLL reports lock on the selected source) and HOLDOVER (a locked source was lost). Its transitions are:

- FREERUN to LOCKING: a source becomes available.
- LOCKING to LOCKED: the lock indication is high and the source did not change.
- LOCKING to FREERUN: no source remains.
- LOCKED to LOCKING: the selected source changes.
- LOCKED to HOLDOVER: no source remains.
- HOLDOVER to LOCKING: a source returns.

Top module: `refsel_top`

## Requirements
- R1: While reset is asserted, the outputs and registers hold their reset values. `dpll_state` is FREERUN (0). `sel_vld` is 0. The force register reads 0x0F. The mode register reads 0x4A, which is the reset pattern 0xCA with bit 7 held at zero. The alarm register reads 0x00.
- R2: An input is qualified when it meets all three conditions: its valid bit is 1, its latched alarm is clear, and its priority is not 0. Among qualified inputs, the lowest priority value wins, and a tie goes to the lower index. With no qualified input, `sel_vld` is 0.
- R3: Revertive mode is mode bit 0 = 1. In revertive mode, the best qualified input replaces the current one on the next clock edge. In non-revertive mode, the current input is kept while it stays qualified.
- R4: The force code decodes as follows. 0x3 selects input 0, 0x4 selects input 1, 0x8 selects input 2 and 0x9 selects input 3. Every other code, including 0x0 and 0xF, means automatic selection.
- R5: A forced input is qualified regardless of its valid bit, its alarm and its priority. Its effective priority is 1, and it wins ties at that level.
- R6: The state machine follows the transitions listed above. State encoding: FREERUN = 0, LOCKING = 1, LOCKED = 2, HOLDOVER = 3.
- R7: While a force code selecting an existing input is active, the state never becomes HOLDOVER.
- R8: A pulse on `alarm_set[i]` latches alarm i on the next edge. Writing 1 to bit i of register 2 clears it. A set in the same cycle as a clear wins.
- R9: When mode bit 6 = 1, a latched alarm clears on the TO_TICKS-th `pps_tick` edge after it was last set; a new set restarts the count. When mode bit 6 = 0, the alarm stays set until software clears it.
- R10: The register map, addressed by `reg_addr`, is: 0 = force code in bits 3:0, 1 = mode byte, 2 = alarm flags (write 1 to clear). Mode bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | N_SRC | Per-input validity from monitors |
| src_prio | input | N_SRC*PRIO_W | Per-input priority, 0 = disabled |
| alarm_set | input | N_SRC | Per-input phase-alarm set pulse |
| pps_tick | input | 1 | One-per-second tick for alarm ageing |
| dpll_lock | input | 1 | Lock indication from the DPLL |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sel_idx | output | IDX_W | Selected input index |
| sel_vld | output | 1 | A source is selected |
| dpll_state | output | 2 | DPLL state code |

## Verification
The assertions take for granted that the alarm set pulses, the clear writes and `pps_tick` are sampled synchronously and are free of X after reset. They also assume the force code is changed only through the register port, so that its effect lags the write by one edge. The stimulus changes every input just after a rising edge and issues writes as single-cycle strobes. It keeps the tick high for long stretches, so that the ageing windows are reached in a bounded number of cycles.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;

    typedef enum logic [1:0] {
        ST_FREERUN  = 2'd0,
        ST_LOCKING  = 2'd1,
        ST_LOCKED   = 2'd2,
        ST_HOLDOVER = 2'd3
    } dpll_st_t;

    localparam logic [3:0] FRC_RESET  = 4'hF;
    localparam logic [7:0] MODE_RESET = 8'hCA;
    localparam logic [7:0] MODE_WMASK = 8'h7F;

    // returns {hit, index}
    function automatic logic [2:0] frc_decode(input logic [3:0] code);
        logic [2:0] r;
        case (code)
            4'h3:    r = 3'b100;
            4'h4:    r = 3'b101;
            4'h8:    r = 3'b110;
            4'h9:    r = 3'b111;
            default: r = 3'b000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/refsel_alarm.sv
`timescale 1ns/1ps
module refsel_alarm #(
    parameter int TO_TICKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic tick_i,
    input  logic to_en_i,
    output logic flag_o
);
    localparam int CNT_W = (TO_TICKS > 1) ? $clog2(TO_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_TICKS - 1);

    logic [CNT_W-1:0] age_q;
    logic             flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            age_q  <= '0;
        end else if (set_i) begin
            flag_q <= 1'b1;
            age_q  <= '0;
        end else if (clr_i) begin
            flag_q <= 1'b0;
            age_q  <= '0;
        end else if (flag_q && to_en_i && tick_i) begin
            if (age_q == LAST) begin
                flag_q <= 1'b0;
                age_q  <= '0;
            end else begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    assign flag_o = flag_q;

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    assert_no_ageing_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !to_en_i && !set_i && !clr_i) |=> flag_o);

endmodule

// File: rtl/refsel_pick.sv
`timescale 1ns/1ps
module refsel_pick #(
    parameter int N_SRC  = 4,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 2
) (
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    input  logic [N_SRC-1:0]        valid_i,
    input  logic [N_SRC-1:0]        alarm_i,
    input  logic                    frc_act_i,
    input  logic [IDX_W-1:0]        frc_idx_i,
    input  logic                    revert_i,
    input  logic [IDX_W-1:0]        cur_idx_i,
    input  logic                    cur_vld_i,
    output logic [IDX_W-1:0]        nxt_idx_o,
    output logic                    nxt_vld_o,
    output logic                    switch_o,
    output logic [N_SRC-1:0]        qual_o
);
    logic [PRIO_W-1:0] eff [N_SRC];
    logic [N_SRC-1:0]  forced;
    logic [N_SRC-1:0]  qual;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign forced[g] = frc_act_i && (frc_idx_i == IDX_W'(g));
        assign eff[g]    = forced[g] ? PRIO_W'(1) : prio_i[g*PRIO_W +: PRIO_W];
        assign qual[g]   = forced[g] ||
                           (valid_i[g] && !alarm_i[g] && (prio_i[g*PRIO_W +: PRIO_W] != '0));
    end

    logic              found;
    logic [IDX_W-1:0]  best_i;
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        found  = 1'b0;
        best_i = '0;
        best_p = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (qual[i] && (!found || eff[i] < best_p || (eff[i] == best_p && forced[i]))) begin
                found  = 1'b1;
                best_i = IDX_W'(i);
                best_p = eff[i];
            end
        end
    end

    logic keep;
    assign keep      = cur_vld_i && qual[cur_idx_i] && !revert_i;
    assign nxt_idx_o = keep ? cur_idx_i : best_i;
    assign nxt_vld_o = keep || found;
    assign switch_o  = nxt_vld_o && cur_vld_i && (nxt_idx_o != cur_idx_i);
    assign qual_o    = qual;

endmodule

// File: rtl/refsel_fsm.sv
`timescale 1ns/1ps
module refsel_fsm
    import refsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     have_i,
    input  logic     switch_i,
    input  logic     lock_i,
    input  logic     frc_act_i,
    input  logic     sel_vld_i,
    output dpll_st_t state_o
);
    dpll_st_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FREERUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREERUN:  if (have_i) state_d = ST_LOCKING;
            ST_LOCKING: begin
                if (!have_i)                 state_d = ST_FREERUN;
                else if (lock_i && !switch_i) state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (!have_i)       state_d = ST_HOLDOVER;
                else if (switch_i) state_d = ST_LOCKING;
            end
            ST_HOLDOVER: if (have_i) state_d = ST_LOCKING;
        endcase
    end

    always_comb state_o = state_q;

    assert_no_holdover_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frc_act_i) |-> (state_o != ST_HOLDOVER));

    assert_locked_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_LOCKED) |-> sel_vld_i);

endmodule

// File: rtl/refsel_top.sv
`timescale 1ns/1ps
module refsel_top
    import refsel_pkg::*;
#(
    parameter int N_SRC    = 4,
    parameter int PRIO_W   = 4,
    parameter int TO_TICKS = 128,
    localparam int IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        src_valid,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    input  logic [N_SRC-1:0]        alarm_set,
    input  logic                    pps_tick,
    input  logic                    dpll_lock,
    input  logic                    reg_wr,
    input  logic [1:0]              reg_addr,
    input  logic [7:0]              reg_wdata,
    output logic [7:0]              reg_rdata,
    output logic [IDX_W-1:0]        sel_idx,
    output logic                    sel_vld,
    output logic [1:0]              dpll_state
);
    localparam logic [1:0] A_FRC  = 2'd0;
    localparam logic [1:0] A_MODE = 2'd1;
    localparam logic [1:0] A_ALM  = 2'd2;
    localparam int MB_REVERT = 0;
    localparam int MB_TOEN   = 6;

    logic [3:0] frc_q;
    logic [7:0] mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frc_q  <= FRC_RESET;
            mode_q <= MODE_RESET & MODE_WMASK;
        end else if (reg_wr) begin
            if (reg_addr == A_FRC)  frc_q  <= reg_wdata[3:0];
            if (reg_addr == A_MODE) mode_q <= reg_wdata & MODE_WMASK;
        end
    end

    logic [2:0]       frc_dec;
    logic             frc_act;
    logic [IDX_W-1:0] frc_idx;
    assign frc_dec = frc_decode(frc_q);
    assign frc_act = frc_dec[2] && (int'(frc_dec[1:0]) < N_SRC);
    assign frc_idx = IDX_W'(frc_dec[1:0]);

    logic [N_SRC-1:0] alm;
    for (genvar g = 0; g < N_SRC; g++) begin : g_alm
        logic clr;
        if (g < 8) begin : g_clr
            assign clr = reg_wr && (reg_addr == A_ALM) && reg_wdata[g];
        end else begin : g_noclr
            assign clr = 1'b0;
        end
        refsel_alarm #(.TO_TICKS(TO_TICKS)) u_alm (
            .clk(clk), .rst_n(rst_n), .set_i(alarm_set[g]), .clr_i(clr),
            .tick_i(pps_tick), .to_en_i(mode_q[MB_TOEN]), .flag_o(alm[g])
        );
    end

    logic [IDX_W-1:0] sel_q, nxt_idx;
    logic             vld_q, nxt_vld, switch;
    logic [N_SRC-1:0] qual;

    refsel_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .prio_i(src_prio), .valid_i(src_valid), .alarm_i(alm),
        .frc_act_i(frc_act), .frc_idx_i(frc_idx), .revert_i(mode_q[MB_REVERT]),
        .cur_idx_i(sel_q), .cur_vld_i(vld_q),
        .nxt_idx_o(nxt_idx), .nxt_vld_o(nxt_vld), .switch_o(switch), .qual_o(qual)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            vld_q <= 1'b0;
        end else begin
            sel_q <= nxt_vld ? nxt_idx : sel_q;
            vld_q <= nxt_vld;
        end
    end

    dpll_st_t st;
    refsel_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .have_i(nxt_vld), .switch_i(switch),
        .lock_i(dpll_lock), .frc_act_i(frc_act), .sel_vld_i(vld_q), .state_o(st)
    );

    always_comb begin
        case (reg_addr)
            A_FRC:   reg_rdata = {4'b0, frc_q};
            A_MODE:  reg_rdata = mode_q;
            A_ALM:   reg_rdata = 8'(alm);
            default: reg_rdata = 8'h00;
        endcase
    end

    assign sel_idx    = sel_q;
    assign sel_vld    = vld_q;
    assign dpll_state = st;

    assert_hold_nonrevertive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mode_q[MB_REVERT] && vld_q && qual[sel_q]) |-> (sel_vld && sel_idx == $past(sel_q)));

    assert_mode_msb_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[7]);

endmodule

// File: tb/refsel_top_tb_top.sv
`timescale 1ns/1ps
module refsel_top_tb_top;
    localparam int CLK_P = 10;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_valid = 4'b1111;
    logic [15:0] src_prio = {4'd4, 4'd1, 4'd2, 4'd3};
    logic [3:0] alarm_set = '0;
    logic       pps_tick = 1'b0;
    logic       dpll_lock = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] sel_idx;
    logic       sel_vld;
    logic [1:0] dpll_state;

    always #(CLK_P/2) clk = ~clk;

    refsel_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_prio(src_prio),
        .alarm_set(alarm_set), .pps_tick(pps_tick), .dpll_lock(dpll_lock),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sel_idx(sel_idx), .sel_vld(sel_vld), .dpll_state(dpll_state)
    );

    typedef struct { int kind; int exp; string tag; } exp_t;
    exp_t q[$];
    int checks = 0;
    int errors = 0;
    exp_t e;
    int obs;

    // monitor: compare every queued expectation at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            e = q.pop_front();
            case (e.kind)
                0: obs = int'(sel_idx);
                1: obs = int'(sel_vld);
                2: obs = int'(dpll_state);
                default: obs = int'(reg_rdata);
            endcase
            checks++;
            if (obs != e.exp) begin
                errors++;
                $display("FAIL %s: actual %0d expected %0d", e.tag, obs, e.exp);
            end
        end
    end

    task automatic chk(input int kind, input int exp, input string tag);
        exp_t x;
        x.kind = kind; x.exp = exp; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
        reg_addr = a;
        chk(3, exp, tag);
        step();
    endtask

    task automatic pulse_alarm(input int i);
        alarm_set[i] = 1'b1;
        step();
        alarm_set = '0;
    endtask

    bit done = 0;

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(2);
        // R1: reset state observed while reset is held
        chk(2, 0, "R1 state");
        chk(1, 0, "R1 sel_vld");
        rd_chk(2'd0, 8'h0F, "R1 force reset");
        rd_chk(2'd1, 8'h4A, "R1 mode reset");
        rd_chk(2'd2, 8'h00, "R1 alarm reset");
        rst_n = 1'b1;
        step();
        chk(0, 2, "R2 best priority");
        chk(2, 1, "R6 FREERUN->LOCKING");
        dpll_lock = 1'b1;
        step();
        chk(2, 2, "R6 LOCKING->LOCKED");
        src_valid[2] = 1'b0;
        step();
        chk(0, 1, "R2 fallback");
        chk(2, 1, "R6 LOCKED->LOCKING on switch");
        step();
        src_valid[2] = 1'b1;
        step();
        chk(0, 1, "R3 non-revertive keeps");
        wr(2'd1, 8'h4B);
        chk(0, 1, "R3 write lag");
        step();
        chk(0, 2, "R3 revertive takes better");
        step();
        wr(2'd1, 8'hCB);
        rd_chk(2'd1, 8'h4B, "R10 mode bit7 reads 0");
        // tie: input 0 and 1 both priority 2
        src_valid[2] = 1'b0;
        src_prio[3:0] = 4'd2;
        step();
        chk(0, 0, "R2 tie lower index");
        src_prio[3:0] = 4'd3;
        src_valid[2] = 1'b1;
        step(2);
        chk(0, 2, "R3 revert back");
        // alarm latch and software clear
        pulse_alarm(2);
        chk(0, 2, "R8 alarm latch lag");
        step();
        chk(0, 1, "R2 alarm disqualifies");
        rd_chk(2'd2, 8'h04, "R8 alarm set");
        wr(2'd2, 8'h04);
        rd_chk(2'd2, 8'h00, "R8 alarm cleared");
        chk(0, 2, "R3 revert after clear");
        // ageing with timeout enabled
        reg_addr = 2'd2;
        pps_tick = 1'b1;
        pulse_alarm(1);
        step(127);
        chk(3, 8'h02, "R9 still set at 127 ticks");
        step();
        chk(3, 8'h00, "R9 cleared at 128 ticks");
        pulse_alarm(1);
        step(100);
        pulse_alarm(1);
        step(127);
        chk(3, 8'h02, "R9 restart on new set");
        step();
        chk(3, 8'h00, "R9 cleared after restart");
        // ageing disabled
        wr(2'd1, 8'h0B);
        reg_addr = 2'd2;
        pulse_alarm(1);
        step(200);
        chk(3, 8'h02, "R9 held when disabled");
        pps_tick = 1'b0;
        wr(2'd2, 8'h02);
        // force while non-revertive
        wr(2'd1, 8'h0A);
        wr(2'd0, 8'h09);
        step();
        chk(0, 2, "R3 force not taken when non-revertive");
        rd_chk(2'd0, 8'h09, "R10 force readback");
        wr(2'd1, 8'h0B);
        step();
        chk(0, 3, "R5 forced wins tie at priority 1");
        step();
        src_valid = 4'b0000;
        pulse_alarm(3);
        step(3);
        chk(0, 3, "R5 forced kept despite failure");
        chk(1, 1, "R5 forced qualified");
        chk(2, 2, "R7 no holdover while forced");
        wr(2'd0, 8'h05);
        step();
        chk(2, 3, "R4 unused code is automatic -> HOLDOVER");
        chk(1, 0, "R2 none qualified");
        src_valid[0] = 1'b1;
        step();
        chk(2, 1, "R6 HOLDOVER->LOCKING");
        chk(0, 0, "R2 returning source");
        step();
        wr(2'd0, 8'h04);
        step();
        chk(0, 1, "R4 code 4 selects input 1");
        wr(2'd0, 8'h00);
        step();
        chk(0, 0, "R4 code 0 automatic");
        src_prio[3:0] = 4'd0;
        step();
        chk(1, 0, "R2 priority 0 disabled");
        chk(2, 0, "R6 LOCKING->FREERUN");
        step(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule